// File: doc/BRIEF.md
# Byte-Lane Write Decode and Bus Direction Control

This block sits between the address sequencer of a common-I/O synchronous flow-through memory and its storage array. The word is 36 bits wide, split into four 9-bit lanes, each holding a data byte and one parity bit. On every rising clock edge the block turns the write controls into per-lane write strobes. The controls are an active-low global write, an active-low byte-write enable and four active-low lane selects. The block also receives the kind of cycle the sequencer reports. It registers the write data and address, and applies the strobes to the array on the following edge.

The block also decides whether the shared data bus is driven. A read cycle drives the bus only while the asynchronous, active-low output enable is low. A cycle that writes any lane keeps the bus released, whatever the output enable does. A deselected cycle releases the bus and writes nothing. Read data is flow-through: after an edge, the read port shows the word at the address captured on that edge, with no extra pipeline register. The array is a small parameterised register file.

Top module: `bw_io_ctrl`

## Requirements
- R1: In a cycle that may write, global write low (`gw_n_i`=0) writes all four lanes, whatever `bwe_n_i` and `bsel_n_i` are. The strobes appear on `lane_we_o` as 4'b1111 after that edge.
- R2: With `gw_n_i`=1 and `bwe_n_i`=0 in a cycle that may write, lane i is written exactly when `bsel_n_i[i]`=0. Lane i occupies word bits [9i+8:9i]: the data byte sits in [9i+7:9i] and its parity in bit 9i+8. `lane_we_o[i]` shows the strobe after the edge.
- R3: With `gw_n_i`=1, and either `bwe_n_i`=1 or `bsel_n_i`=4'b1111, the cycle is a read. No lane is written, and the bus is driven when the output enable is low.
- R4: Cycle kind 2'd1 (a start by the processor strobe) is always a read. The write inputs have no effect in it.
- R5: Cycle kind 2'd2 (a start by the controller strobe, issued only while the processor strobe is inactive) writes the lanes its controls select. The data on `wr_data_i` at that same edge is stored.
- R6: Cycle kind 2'd3 (burst continue or suspend) writes the lanes its controls select, as in R5.
- R7: After the edge of any cycle that writes at least one lane, `drive_en_o` is 0, even with `oe_n_i`=0 and even for a single-lane write.
- R8: In a read cycle, `drive_en_o` follows `!oe_n_i` combinationally, with no clock edge needed.
- R9: After the edge of a read cycle, `rd_data_o` holds the word at the address captured on that edge. This includes every write issued on earlier edges.
- R10: Cycle kind 2'd0 (deselected) writes nothing and leaves `drive_en_o` at 0.
- R11: While and after synchronous reset (`rst`=1), no lane strobe is pending and `drive_en_o` is 0 until a read cycle is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cyc_kind_i | input | 2 | Cycle kind from the sequencer: 0 deselected, 1 processor start, 2 controller start, 3 continue |
| addr_i | input | ADDR_W | Word address for this cycle |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bsel_n_i | input | 4 | Lane selects, active low, bit i for lane i |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| wr_data_i | input | 36 | Write data, four 9-bit lanes |
| rd_data_o | output | 36 | Flow-through read data |
| drive_en_o | output | 1 | High when the bus pads should drive `rd_data_o` |
| lane_we_o | output | 4 | Per-lane write strobes applied to the array on the next edge |

## Verification
The assertions assume the following about the inputs:
- The sequencer only ever presents the four legal cycle-kind codes, already resolved so that a controller start never coincides with an active processor strobe.
- Every control input is known and stable across the sampling edge.

The stimulus respects these assumptions. It changes every synchronous input two nanoseconds after a rising edge and holds it until the next one. It uses only the four codes, and moves the output enable by itself only in the middle of a read cycle.

// File: rtl/bwio_pkg.sv
package bwio_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_PSTART = 2'd1,
        CYC_CSTART = 2'd2,
        CYC_NEXT   = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic [LANES-1:0]  mask;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    // Lanes requested by the write controls, before the cycle kind is applied.
    function automatic logic [LANES-1:0] lanes_requested(
        input logic             gw_n,
        input logic             bwe_n,
        input logic [LANES-1:0] bsel_n
    );
        logic [LANES-1:0] r;
        if (!gw_n)       r = '1;
        else if (!bwe_n) r = ~bsel_n;
        else             r = '0;
        return r;
    endfunction

    // Only controller starts and continue cycles may carry a write.
    function automatic logic kind_may_write(input cyc_kind_e k);
        return (k == CYC_CSTART) || (k == CYC_NEXT);
    endfunction

endpackage

// File: rtl/bw_decode.sv
module bw_decode
    import bwio_pkg::*;
(
    input  cyc_kind_e        kind_i,
    input  logic             gw_n_i,
    input  logic             bwe_n_i,
    input  logic [LANES-1:0] bsel_n_i,
    output logic [LANES-1:0] lane_we_o,
    output logic             is_read_o
);

    logic [LANES-1:0] req;

    always_comb begin
        req       = lanes_requested(gw_n_i, bwe_n_i, bsel_n_i);
        lane_we_o = kind_may_write(kind_i) ? req : '0;
        is_read_o = (kind_i != CYC_IDLE) && (lane_we_o == '0);
    end

endmodule

// File: rtl/bw_capture.sv
module bw_capture
    import bwio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cyc_kind_e         kind_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic              is_read_i,
    output logic [ADDR_W-1:0] addr_q,
    output wr_req_t           wreq_q,
    output logic              rd_active_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q      <= '0;
            wreq_q      <= '0;
            rd_active_q <= 1'b0;
        end else begin
            if (kind_i != CYC_IDLE) begin
                addr_q <= addr_i;
            end
            wreq_q.mask <= lane_we_i;
            wreq_q.data <= data_i;
            rd_active_q <= is_read_i;
        end
    end

    // R1: a low global write on a write-capable cycle strobes every lane
    a_r1_global_all: assert property (@(posedge clk) disable iff (rst)
        (kind_may_write(kind_i) && !gw_n_i) |=> (wreq_q.mask == '1));

    // R3: byte-write enable and global write both high give a read
    a_r3_no_write_read: assert property (@(posedge clk) disable iff (rst)
        (kind_i != CYC_IDLE && gw_n_i && bwe_n_i) |=> (wreq_q.mask == '0 && rd_active_q));

    // R4: a processor-strobe start never writes
    a_r4_proc_read: assert property (@(posedge clk) disable iff (rst)
        (kind_i == CYC_PSTART) |=> (wreq_q.mask == '0 && rd_active_q));

    // R10: a deselected cycle neither writes nor reads
    a_r10_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        (kind_i == CYC_IDLE) |=> (wreq_q.mask == '0 && !rd_active_q));

endmodule

// File: rtl/bw_array.sv
module bw_array
    import bwio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  wr_req_t           wreq_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wreq_i.mask[g]) begin
                mem[addr_i] <= wreq_i.data[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

endmodule

// File: rtl/bw_io_ctrl.sv
module bw_io_ctrl
    import bwio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cyc_kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              gw_n_i,
    input  logic              bwe_n_i,
    input  logic [LANES-1:0]  bsel_n_i,
    input  logic              oe_n_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              drive_en_o,
    output logic [LANES-1:0]  lane_we_o
);

    cyc_kind_e         kind;
    logic [LANES-1:0]  lane_we;
    logic              is_read;
    logic [ADDR_W-1:0] addr_q;
    wr_req_t           wreq_q;
    logic              rd_active_q;

    assign kind = cyc_kind_e'(cyc_kind_i);

    bw_decode u_dec (
        .kind_i    (kind),
        .gw_n_i    (gw_n_i),
        .bwe_n_i   (bwe_n_i),
        .bsel_n_i  (bsel_n_i),
        .lane_we_o (lane_we),
        .is_read_o (is_read)
    );

    bw_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .kind_i      (kind),
        .gw_n_i      (gw_n_i),
        .bwe_n_i     (bwe_n_i),
        .addr_i      (addr_i),
        .data_i      (wr_data_i),
        .lane_we_i   (lane_we),
        .is_read_i   (is_read),
        .addr_q      (addr_q),
        .wreq_q      (wreq_q),
        .rd_active_q (rd_active_q)
    );

    bw_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk     (clk),
        .addr_i  (addr_q),
        .wreq_i  (wreq_q),
        .rdata_o (rd_data_o)
    );

    // Output enable is not registered: it acts without waiting for an edge.
    assign drive_en_o = rd_active_q & ~oe_n_i;
    assign lane_we_o  = wreq_q.mask;

    // R7: any pending lane write keeps the bus released
    a_r7_hiz_on_write: assert property (@(posedge clk) disable iff (rst)
        (wreq_q.mask != '0) |-> !drive_en_o);

    // R8: a high output enable always releases the bus
    a_r8_oe_release: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !drive_en_o);

endmodule

// File: tb/sim_bw_io_ctrl.sv
`timescale 1ns/1ps
module sim_bw_io_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  kind = 2'd0;
    logic [3:0]  addr = '0;
    logic        gw_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        oe_n = 1'b0;
    logic [35:0] wdat = '0;
    logic [35:0] rd_data;
    logic        drive_en;
    logic [3:0]  lane_we;

    int total = 0;
    int failed = 0;
    bit done = 0;
    logic [35:0] model [16];

    always #10 clk = ~clk;

    bw_io_ctrl #(.ADDR_W(4)) u0 (
        .clk(clk), .rst(rst), .cyc_kind_i(kind), .addr_i(addr),
        .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bsel_n_i(bsel_n), .oe_n_i(oe_n),
        .wr_data_i(wdat), .rd_data_o(rd_data), .drive_en_o(drive_en),
        .lane_we_o(lane_we)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] k, input logic g,
                                            input logic b, input logic [3:0] s);
        if (k == 2'd0 || k == 2'd1) return 4'h0;
        if (!g) return 4'hF;
        if (!b) return ~s;
        return 4'h0;
    endfunction

    function automatic logic [35:0] pat(input int i, input int salt);
        logic [63:0] v;
        v = 64'(i + 1) * 64'h9A3C_5E71 + 64'(salt) * 64'h1357_9BDF;
        return v[35:0] ^ 36'hF0F0_F0F0F;
    endfunction

    // One cycle: drive inputs, take the edge, return 2 ns later.
    task automatic cyc(input logic [1:0] k, input logic [3:0] a, input logic g,
                       input logic b, input logic [3:0] s, input logic [35:0] d);
        kind = k; addr = a; gw_n = g; bwe_n = b; bsel_n = s; wdat = d;
        @(posedge clk);
        #2;
    endtask

    // Write-capable cycle with model update and strobe/bus checks.
    task automatic wr(input string tag, input logic [1:0] k, input logic [3:0] a,
                      input logic g, input logic b, input logic [3:0] s, input logic [35:0] d);
        logic [3:0] m;
        m = exp_mask(k, g, b, s);
        cyc(k, a, g, b, s, d);
        for (int i = 0; i < 4; i++)
            if (m[i]) model[a][9*i +: 9] = d[9*i +: 9];
        chk({tag, " lane strobes"}, 36'(lane_we), 36'(m));
        chk({tag, " R7 bus release"}, 36'(drive_en), 36'(m == 4'h0));
    endtask

    // Read via a processor start, with write inputs active to show they are ignored.
    task automatic rd(input string tag, input logic [3:0] a);
        cyc(2'd1, a, 1'b0, 1'b0, 4'h0, ~model[a]);
        chk({tag, " R9 read data"}, rd_data, model[a]);
        chk({tag, " R4 no strobe"}, 36'(lane_we), 36'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failed++;
            total++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            $display("  %0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R11 reset bus released", 36'(drive_en), 36'h0);
        chk("R11 reset no strobe", 36'(lane_we), 36'h0);
        rst = 1'b0;
        cyc(2'd0, 4'h0, 1'b1, 1'b1, 4'hF, '0);
        chk("R11 after reset idle", 36'(drive_en), 36'h0);

        // R1 / R5: fill every address with global writes from controller starts.
        for (int a = 0; a < 16; a++)
            wr("R1 R5 global fill", 2'd2, 4'(a), 1'b0, 1'b1, 4'hF, pat(a, 0));
        for (int a = 0; a < 16; a++)
            rd("R1 R5 fill readback", 4'(a));

        // R2 / R6: every lane-select pattern via continue cycles.
        for (int s = 0; s < 16; s++)
            wr("R2 R6 lane sweep", 2'd3, 4'(s), 1'b1, 1'b0, 4'(s), pat(s, 7));
        for (int s = 0; s < 16; s++)
            rd("R2 lane readback", 4'(s));

        // R1: global write overrides a partial select pattern.
        wr("R1 override", 2'd3, 4'h5, 1'b0, 1'b0, 4'b1010, pat(5, 3));
        rd("R1 override readback", 4'h5);

        // R3: byte-write enable high with all selects low reads.
        cyc(2'd2, 4'h6, 1'b1, 1'b1, 4'h0, pat(6, 9));
        chk("R3 read bus driven", 36'(drive_en), 36'h1);
        chk("R3 read data", rd_data, model[6]);
        chk("R3 no strobe", 36'(lane_we), 36'h0);
        rd("R3 unchanged", 4'h6);

        // R4: processor start with every write input active.
        cyc(2'd1, 4'h7, 1'b0, 1'b0, 4'h0, pat(7, 11));
        chk("R4 bus driven", 36'(drive_en), 36'h1);
        chk("R4 old data shown", rd_data, model[7]);
        rd("R4 unchanged", 4'h7);

        // R10: deselected cycle with global write low.
        cyc(2'd0, 4'h8, 1'b0, 1'b0, 4'h0, pat(8, 13));
        chk("R10 bus released", 36'(drive_en), 36'h0);
        chk("R10 no strobe", 36'(lane_we), 36'h0);
        rd("R10 unchanged", 4'h8);

        // R8: output enable acts between edges.
        cyc(2'd3, 4'h9, 1'b1, 1'b1, 4'hF, '0);
        chk("R8 read driven", 36'(drive_en), 36'h1);
        oe_n = 1'b1; #1;
        chk("R8 oe high releases", 36'(drive_en), 36'h0);
        oe_n = 1'b0; #1;
        chk("R8 oe low drives", 36'(drive_en), 36'h1);
        chk("R9 data while driven", rd_data, model[9]);

        // R7 / R9: back-to-back single-lane writes to one address, then read.
        wr("R7 lane0", 2'd3, 4'hA, 1'b1, 1'b0, 4'b1110, pat(10, 21));
        wr("R7 lane3", 2'd3, 4'hA, 1'b1, 1'b0, 4'b0111, pat(10, 22));
        rd("R9 merge readback", 4'hA);

        done = 1;
        $display("  %0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule